// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Controller

This block is the host side of a three-wire link to a chain of identical serial converters. The devices are wired so that each one's serial output feeds the next one's data input. The upstream end of the chain has its data input tied low. The downstream end drives the host's data input. The controller owns two outputs, a convert strobe (`cnv`) and a serial clock (`sck`), and it has one serial data input (`sdo_in`).

A `start` pulse begins a frame. The controller raises `cnv` while `sck` is still low, which puts the devices into chained operation. It holds `cnv` high for a conversion wait set by `conv_cycles`. It then issues one clock pulse per bit for the whole chain and samples the data line each time it drives `sck` low. When the last bit is in, the controller drops `cnv` and puts out all words at once with a one-cycle strobe. It then holds off new frames for an acquisition gap set by `gap_cycles`.

The number of devices, the word width, and the serial clock half-period are parameters. The two timing counts are inputs and are latched when a frame is accepted.

Top module: `chain_readout_ctrl`

## Requirements
- R1: `sck` is low whenever the block is not clocking bits, and `cnv` only ever rises while `sck` is low.
- R2: After a start is accepted, `cnv` goes high. The first rising edge of `sck` comes exactly max(`conv_cycles`,1)+`SCK_HALF` clock cycles after `cnv` rises (a value of 0 counts as 1). `cnv` stays high through every `sck` pulse of the frame.
- R3: A frame contains exactly `N_DEV`×`WORD_W` rising edges of `sck`. Each high phase of `sck` lasts `SCK_HALF` clock cycles.
- R4: `sdo_in` is sampled at the clock edge where the block drives `sck` from high to low. The first bit sampled in a frame is the most significant bit of word 0, and each word arrives MSB first.
- R5: Word i sits at `words[i*WORD_W +: WORD_W]`. Word 0 comes from the device that drives `sdo_in`, and word i comes from the device i positions further upstream.
- R6: `words_valid` is high for exactly one cycle per frame, in the cycle right after the last falling edge of `sck`. In that same cycle `cnv` is already low. `words` holds its value until the next frame completes.
- R7: After `cnv` falls, it stays low for at least `gap_cycles`+2 clock cycles. The `gap_cycles` value used is the one latched when the frame was accepted.
- R8: `busy` is high from the cycle after a start is accepted until the gap ends. A `start` seen while `busy` is high is ignored: it causes no extra `cnv` rise.
- R9: After reset, `cnv`, `sck`, `busy` and `words_valid` are 0 and `words` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, taken only when idle |
| conv_cycles | input | CNT_W | Conversion wait in clock cycles (0 counts as 1) |
| gap_cycles | input | CNT_W | Acquisition gap after a frame, in clock cycles |
| sdo_in | input | 1 | Serial data from the nearest device |
| cnv | output | 1 | Convert strobe to all devices |
| sck | output | 1 | Serial clock to all devices |
| busy | output | 1 | Frame or gap in progress |
| words_valid | output | 1 | One-cycle strobe: `words` updated |
| words | output | N_DEV*WORD_W | Captured words, index 0 from the nearest device |

## Verification
Some properties are checked on every cycle by the assertions: `cnv` never rises with `sck` high, `sck` is never high without `cnv`, the bit counter stays in range, `cnv` is low during the gap, a rise of `cnv` only happens from idle, and the valid strobe never lasts two cycles. Other properties only the bench scenarios can show, by comparing against a shift-register model of the device chain loaded with random samples. These are the exact conversion-wait delay, the total pulse count, the word ordering, the gap length under a held `start`, and that a `start` or a change to the timing inputs in mid-frame leaves the frame unchanged.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;

  // Serial bits needed to read a whole chain.
  function automatic int unsigned chain_bits(int unsigned n_dev, int unsigned width);
    return n_dev * width;
  endfunction

  // Conversion wait actually applied: a zero request is stretched to one cycle.
  function automatic logic [31:0] conv_wait(logic [31:0] req);
    return (req == 32'd0) ? 32'd1 : req;
  endfunction

endpackage

// File: rtl/crd_sck_gen.sv
module crd_sck_gen #(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_evt
);
  localparam int unsigned PW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [PW-1:0] ph_q;
  logic          sck_q;
  logic          phase_end;

  assign phase_end = (ph_q == PW'(SCK_HALF - 1));
  // Edge at which sck is driven high->low: data is captured on this edge.
  assign fall_evt  = run && phase_end && sck_q;
  assign sck       = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else if (phase_end) begin
      ph_q  <= '0;
      sck_q <= ~sck_q;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  p_sck_rests_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_q);

endmodule

// File: rtl/crd_sequencer.sv
module crd_sequencer
  import chain_rd_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TOTAL = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] conv_cycles,
  input  logic [CNT_W-1:0] gap_cycles,
  input  logic             fall_evt,
  output logic             cnv,
  output logic             run,
  output logic             frame_done,
  output logic             busy
);
  localparam int unsigned BW = $clog2(TOTAL + 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gap_q;
  logic [BW-1:0]    bit_q;
  logic             cnv_q;

  logic accept, conv_done, gap_done;

  assign accept     = (state_q == ST_IDLE) && start;
  assign conv_done  = (state_q == ST_CONV) && (cnt_q == CNT_W'(1));
  assign frame_done = (state_q == ST_SHIFT) && fall_evt && (bit_q == BW'(TOTAL - 1));
  assign gap_done   = (state_q == ST_GAP) && (cnt_q == '0);

  assign run  = (state_q == ST_SHIFT);
  assign busy = (state_q != ST_IDLE);
  assign cnv  = cnv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      bit_q   <= '0;
      cnv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_CONV;
            cnv_q   <= 1'b1;
            cnt_q   <= CNT_W'(conv_wait(32'(conv_cycles)));
            gap_q   <= gap_cycles;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (frame_done) begin
            state_q <= ST_GAP;
            cnv_q   <= 1'b0;
            cnt_q   <= gap_q;
          end else if (fall_evt) begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_done) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_cnv_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV || state_q == ST_SHIFT) |-> cnv_q);

  p_bit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (bit_q < BW'(TOTAL)));

  p_gap_cnv_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> !cnv_q);

  p_rise_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_q) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: rtl/crd_capture.sv
module crd_capture #(
  parameter int unsigned N_DEV  = 3,
  parameter int unsigned WORD_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample,
  input  logic                    sdi,
  input  logic                    done,
  output logic [N_DEV*WORD_W-1:0] words,
  output logic                    valid
);
  localparam int unsigned TOTAL = N_DEV * WORD_W;

  logic [TOTAL-2:0] sr_q;
  logic [TOTAL-1:0] stream;
  logic [TOTAL-1:0] ordered;
  logic [TOTAL-1:0] words_q;
  logic             valid_q;

  // Includes the bit arriving on the current edge.
  assign stream = {sr_q, sdi};

  // The earliest bit received is the MSB of word 0.
  for (genvar g = 0; g < N_DEV; g++) begin : g_slot
    assign ordered[g*WORD_W +: WORD_W] = stream[TOTAL-1-g*WORD_W -: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      words_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (sample) sr_q <= stream[TOTAL-2:0];
      if (done)   words_q <= ordered;
      valid_q <= done;
    end
  end

  assign words = words_q;
  assign valid = valid_q;

  p_done_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sample);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl
  import chain_rd_pkg::*;
#(
  parameter int unsigned N_DEV    = 3,
  parameter int unsigned WORD_W   = 14,
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned CNT_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        conv_cycles,
  input  logic [CNT_W-1:0]        gap_cycles,
  input  logic                    sdo_in,
  output logic                    cnv,
  output logic                    sck,
  output logic                    busy,
  output logic                    words_valid,
  output logic [N_DEV*WORD_W-1:0] words
);
  localparam int unsigned TOTAL = chain_bits(N_DEV, WORD_W);

  logic run;
  logic fall_evt;
  logic frame_done;

  crd_sequencer #(
    .CNT_W (CNT_W),
    .TOTAL (TOTAL)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .conv_cycles (conv_cycles),
    .gap_cycles  (gap_cycles),
    .fall_evt    (fall_evt),
    .cnv         (cnv),
    .run         (run),
    .frame_done  (frame_done),
    .busy        (busy)
  );

  crd_sck_gen #(
    .SCK_HALF (SCK_HALF)
  ) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sck      (sck),
    .fall_evt (fall_evt)
  );

  crd_capture #(
    .N_DEV  (N_DEV),
    .WORD_W (WORD_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (fall_evt),
    .sdi    (sdo_in),
    .done   (frame_done),
    .words  (words),
    .valid  (words_valid)
  );

  p_cnv_rise_sck_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> !sck);

  p_sck_inside_cnv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> cnv);

  p_valid_after_cnv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    words_valid |-> !cnv);

endmodule

// File: tb/chain_readout_ctrl_bench.sv
`timescale 1ns/1ps
module chain_readout_ctrl_bench;
  localparam int N    = 3;
  localparam int W    = 14;
  localparam int HALF = 2;
  localparam int CW   = 8;
  localparam int TOT  = N * W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [CW-1:0]  conv_cycles = '0;
  logic [CW-1:0]  gap_cycles = '0;
  logic           sdo_in;
  logic           cnv, sck, busy, words_valid;
  logic [TOT-1:0] words;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chain_readout_ctrl #(
    .N_DEV(N), .WORD_W(W), .SCK_HALF(HALF), .CNT_W(CW)
  ) u_chain_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .conv_cycles(conv_cycles),
    .gap_cycles(gap_cycles), .sdo_in(sdo_in), .cnv(cnv), .sck(sck),
    .busy(busy), .words_valid(words_valid), .words(words)
  );

  function automatic int exp_first_rise(int c);
    return ((c == 0) ? 1 : c) + HALF;
  endfunction

  function automatic int exp_pulses();
    return N * W;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Device chain model: dev[0] drives the host, dev[N-1] has its input tied low.
  logic [W-1:0] dev   [N];
  logic [W-1:0] exp_w [N];
  initial for (int k = 0; k < N; k++) begin dev[k] = '0; exp_w[k] = '0; end
  assign sdo_in = dev[0][W-1];

  initial begin
    forever begin
      @(posedge cnv);
      for (int k = 0; k < N; k++) begin
        dev[k]   = W'($urandom);
        exp_w[k] = dev[k];
      end
      repeat (TOT) begin
        @(negedge sck);
        #1;
        for (int k = 0; k < N; k++)
          dev[k] = {dev[k][W-2:0], (k == N-1) ? 1'b0 : dev[k+1][W-1]};
      end
    end
  end

  // Monitor, sampled on the falling clock edge.
  int  rises = 0, pre = 0, hi_run = 0, low_run = 0;
  int  lat_conv = 0, lat_gap = 0, prev_gap = 0;
  int  cnv_rises = 0, valid_cnt = 0;
  bit  seen = 0, have_prev = 0;
  bit  p_cnv = 0, p_sck = 0, p_valid = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cnv && !p_cnv) begin
        chk(!sck, "R1", "sck at cnv rise", sck, 0);
        if (have_prev)
          chk(low_run >= prev_gap + 2, "R7", "cnv low run", low_run, prev_gap + 2);
        lat_conv = int'(conv_cycles);
        lat_gap  = int'(gap_cycles);
        rises = 0; pre = 1; seen = 0;
        cnv_rises++;
      end else if (cnv && !seen) begin
        if (sck) begin
          seen = 1;
          chk(pre == exp_first_rise(lat_conv), "R2", "cycles to first sck", pre,
              exp_first_rise(lat_conv));
        end else pre++;
      end
      if (sck && !p_sck) begin
        rises++;
        chk(cnv, "R2", "cnv during sck pulse", cnv, 1);
      end
      if (sck) hi_run++;
      if (!sck && p_sck) begin
        chk(hi_run == HALF, "R3", "sck high phase", hi_run, HALF);
        hi_run = 0;
      end
      if (!cnv && p_cnv) low_run = 1;
      else if (!cnv) low_run++;
      if (words_valid) begin
        chk(!p_valid, "R6", "valid width", 2, 1);
        chk(!cnv, "R6", "cnv at valid", cnv, 0);
        chk(rises == exp_pulses(), "R3", "sck pulses", rises, exp_pulses());
        for (int i = 0; i < N; i++)
          chk(words[i*W +: W] == exp_w[i], (i == 0) ? "R4" : "R5", "word",
              words[i*W +: W], exp_w[i]);
        have_prev = 1;
        prev_gap = lat_gap;
        valid_cnt++;
      end
    end
    p_cnv = cnv; p_sck = sck; p_valid = words_valid;
  end

  task automatic do_frame(int c, int g, bit poke);
    int base, v0;
    while (busy) @(negedge clk);
    conv_cycles = CW'(c);
    gap_cycles  = CW'(g);
    base = cnv_rises;
    v0 = valid_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8", "busy after accept", busy, 1);
    chk(cnv, "R2", "cnv after accept", cnv, 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      conv_cycles = CW'(c + 91);
      gap_cycles  = CW'(g + 37);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (valid_cnt == v0) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(words[i*W +: W] == exp_w[i], "R6", "words held", words[i*W +: W], exp_w[i]);
    chk(cnv_rises - base == 1, "R8", "cnv rises per frame", cnv_rises - base, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    chk(!cnv && !sck && !busy && !words_valid, "R9", "control outputs in reset",
        {cnv, sck, busy, words_valid}, 0);
    chk(words == '0, "R9", "words in reset", words, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sck && !cnv, "R1", "idle sck/cnv", {sck, cnv}, 0);

    do_frame(0, 0, 0);        // shortest waits
    do_frame(255, 255, 0);    // longest waits
    do_frame(5, 3, 1);        // start and timing change mid-frame
    do_frame(1, 10, 0);

    // Back-to-back frames with start held high: gap is the only spacing.
    while (busy) @(negedge clk);
    conv_cycles = CW'(4);
    gap_cycles  = CW'(6);
    begin
      int v0;
      v0 = valid_cnt;
      start = 1'b1;
      while (valid_cnt < v0 + 3) @(negedge clk);
      start = 1'b0;
    end

    for (int t = 0; t < 25; t++)
      do_frame(int'($urandom_range(0, 40)), int'($urandom_range(0, 20)), ($urandom_range(0, 3) == 0));

    repeat (40) @(negedge clk);
    chk(!busy && !cnv && !sck, "R8", "idle at end", {busy, cnv, sck}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule